// File: doc/BRIEF.md
# Burst SRAM Access Controller

This block is the synchronous front end of a common-I/O, flow-through burst SRAM. On every rising clock edge it samples three chip selects, two access-start strobes, an advance input, the write controls (a write-all strobe, a byte-write gate and one strobe per byte) and the address. A new access loads the address. A two-bit beat counter then walks the four words of an aligned group in one of two orders. The order-select input picks the order. Low gives linear order: the low address bits are added to the beat number. High gives interleaved order: the low address bits are XORed with the beat number.

The block writes a word-wide array with byte enables. It returns the word at the current burst address without a register stage. It also produces the drive enable for the shared data bus. That enable drops in any cycle whose write controls request a write, whatever the output-enable input says. The primary strobe takes priority over the secondary one. Only the secondary strobe can start a write in its own cycle.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While reset is low, and after reset until the first access, `bus_drive` is 0.
- R2: A strobe is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe seen with the chip deselected loads no address, writes nothing and ends any access, so `bus_drive` becomes 0 and `rdata` keeps the previous word.
- R3: When `strb_pri_n` and `strb_sec_n` are both 0, the primary strobe wins. The address is loaded as a read, and the write controls sampled on that edge write nothing.
- R4: An accepted strobe loads `addr` into the address register and seeds the burst at beat 0. From the next edge on, `rdata` shows the word at `addr`.
- R5: With `order_sel`=0, beat b of a burst that starts at low bits s reads low address bits (s+b) mod 4.
- R6: With `order_sel`=1, beat b reads low address bits s XOR b. Any value of `order_sel` other than 0 selects interleaved order, which matches a pulled-up pin that is left open.
- R7: The beat counter steps only on an edge where `adv_n`=0. It wraps from beat 3 back to beat 0. The upper address bits `addr[AW-1:2]` never change within a burst.
- R8: `wr_all_n`=0 writes all bytes of the target word. The target is `addr` on a secondary-strobe edge, or the current burst address in a later cycle of the access.
- R9: With `wr_all_n`=1 and `wr_en_n`=0, byte i (bits 8i+7:8i) is written only when `byte_wr_n[i]`=0. With `wr_all_n`=1 and `wr_en_n`=1, no byte is written.
- R10: `bus_drive` is 1 only when an access is active, `out_en_n`=0 and no write is requested. In the cycle a write is requested, it is 0 regardless of `out_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| strb_pri_n | input | 1 | Primary access-start strobe, active low, has priority |
| strb_sec_n | input | 1 | Secondary access-start strobe, active low, may write |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_en_n | input | 1 | Gate for the per-byte strobes, active low |
| byte_wr_n | input | NB | Per-byte write strobes, active low |
| out_en_n | input | 1 | Output enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, otherwise interleaved |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Word at the current burst address |
| bus_drive | output | 1 | Drive enable for the shared data bus |

## Verification
The bench drives every input 5 ns after a rising edge. Address loads, beat steps and array writes all happen at the next rising edge. So `rdata` for a new access or a new beat is sampled 5 ns after that edge, in the same cycle and with no extra latency. `bus_drive` follows the write controls within the cycle they are driven, so it is sampled 1 ns after they change, before any edge. A write is confirmed by a later read of the same word.

// File: rtl/sram_burst_pkg.sv
// Package: shared types and the burst-order function.
// Assumes bursts span four words, selected by the two low address bits.
package sram_burst_pkg;
    typedef logic [1:0] beat_t;

    // Low address bits for one beat: XOR for interleaved order, add for linear.
    function automatic beat_t burst_lo(beat_t start, beat_t beat, logic interleave);
        return interleave ? (start ^ beat) : beat_t'(start + beat);
    endfunction
endpackage

// File: rtl/sram_burst_seq.sv
// Module: address register and two-bit beat counter.
// Loads the full address on load_i. Steps the beat on adv_n_i low while active.
// clear_i ends the access. Assumes load_i and clear_i are never high together.
module sram_burst_seq #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          clear_i,
    input  logic          adv_n_i,
    input  logic          order_sel_i,
    input  logic [AW-1:0] addr_i,
    output logic          active_o,
    output logic [AW-1:0] cur_addr_o
);
    import sram_burst_pkg::*;
    localparam int HW = AW - 2;

    logic [HW-1:0] hi_q;
    beat_t         start_q;
    beat_t         beat_q;
    logic          active_q;
    logic          ilv;

    // Pick the order. Anything other than a clean 0 means interleaved.
    always_comb begin
        if (order_sel_i == 1'b0) ilv = 1'b0;
        else                     ilv = 1'b1;
    end

    // Address register, beat counter and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            start_q  <= '0;
            beat_q   <= '0;
            active_q <= 1'b0;
        end else if (load_i) begin
            hi_q     <= addr_i[AW-1:2];
            start_q  <= addr_i[1:0];
            beat_q   <= '0;
            active_q <= 1'b1;
        end else if (clear_i) begin
            active_q <= 1'b0;
        end else if (active_q && !adv_n_i) begin
            beat_q   <= beat_q + 2'd1;
        end
    end

    assign active_o   = active_q;
    assign cur_addr_o = {hi_q, burst_lo(start_q, beat_q, ilv)};

    // R4: a load makes the loaded address current on the next edge.
    p_load_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cur_addr_o == $past(addr_i)));
    // R7: the upper bits stay put unless a new access loads them.
    p_upper_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cur_addr_o[AW-1:2] == $past(cur_addr_o[AW-1:2])));
    // R7: with no advance and no order change, the address holds.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=>
            ((cur_addr_o == $past(cur_addr_o)) || (order_sel_i != $past(order_sel_i))));
    // R5: in a linear burst, each advance adds one to the low bits, mod 4.
    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i && active_q && !adv_n_i && order_sel_i == 1'b0) |=>
            ((order_sel_i != 1'b0) ||
             (cur_addr_o[1:0] == 2'($past(cur_addr_o[1:0]) + 2'd1))));
endmodule

// File: rtl/sram_write_decode.sv
// Module: byte-write decode.
// Write-all forces every byte. Otherwise the byte gate enables the per-byte strobes.
// allow_i says whether this cycle may write. wr_req_o reports a request even
// when the write is not allowed, so the bus is still released.
module sram_write_decode #(
    parameter int NB = 4
) (
    input  logic          wr_all_n_i,
    input  logic          wr_en_n_i,
    input  logic [NB-1:0] byte_wr_n_i,
    input  logic          allow_i,
    output logic [NB-1:0] byte_we_o,
    output logic          wr_req_o
);
    logic [NB-1:0] mask;

    // Form the requested byte mask from the three write controls.
    always_comb begin
        if (!wr_all_n_i)     mask = '1;
        else if (!wr_en_n_i) mask = ~byte_wr_n_i;
        else                 mask = '0;
    end

    assign byte_we_o = allow_i ? mask : '0;
    assign wr_req_o  = |mask;

    // Guard the decode against the write-control rules.
    always_comb begin
        if (allow_i && !wr_all_n_i)
            p_all_bytes_r8: assert (byte_we_o == {NB{1'b1}});
        if (wr_all_n_i && wr_en_n_i)
            p_gate_off_r9: assert (byte_we_o == '0 && !wr_req_o);
    end
endmodule

// File: rtl/sram_word_array.sv
// Module: word-wide array model with per-byte write enables.
// The read is asynchronous (flow-through). The write happens on the rising edge.
// The contents have no reset.
module sram_word_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int DW = 8 * NB
) (
    input  logic          clk,
    input  logic [NB-1:0] we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // One write lane per byte.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        // Store this byte lane when its enable is high.
        always_ff @(posedge clk) begin
            if (we_i[g]) mem[waddr_i][8*g +: 8] <= wdata_i[8*g +: 8];
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sram_burst_ctrl.sv
// Module: top of the burst SRAM access controller.
// Decodes the chip selects and the two strobes (primary wins), drives the
// burst sequencer, decodes byte writes into the array, and makes the bus
// drive enable. Assumes all inputs are synchronous to clk.
module sram_burst_ctrl #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int DW = 8 * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          strb_pri_n,
    input  logic          strb_sec_n,
    input  logic          adv_n,
    input  logic          wr_all_n,
    input  logic          wr_en_n,
    input  logic [NB-1:0] byte_wr_n,
    input  logic          out_en_n,
    input  logic          order_sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          bus_drive
);
    logic          chip_sel;
    logic          start_pri;
    logic          start_sec;
    logic          deselect;
    logic          active;
    logic          allow_wr;
    logic          wr_req;
    logic [NB-1:0] byte_we;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] waddr;

    // Decode the strobes. The primary strobe masks the secondary one.
    always_comb begin
        chip_sel  = !sel_a_n && sel_b && !sel_c_n;
        start_pri = chip_sel && !strb_pri_n;
        start_sec = chip_sel && strb_pri_n && !strb_sec_n;
        deselect  = !chip_sel && (!strb_pri_n || !strb_sec_n);
        allow_wr  = start_sec || (active && strb_pri_n && strb_sec_n);
        waddr     = start_sec ? addr : cur_addr;
    end

    sram_burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_pri || start_sec),
        .clear_i    (deselect),
        .adv_n_i    (adv_n),
        .order_sel_i(order_sel),
        .addr_i     (addr),
        .active_o   (active),
        .cur_addr_o (cur_addr)
    );

    sram_write_decode #(.NB(NB)) u_wdec (
        .wr_all_n_i (wr_all_n),
        .wr_en_n_i  (wr_en_n),
        .byte_wr_n_i(byte_wr_n),
        .allow_i    (allow_wr),
        .byte_we_o  (byte_we),
        .wr_req_o   (wr_req)
    );

    sram_word_array #(.AW(AW), .NB(NB), .DW(DW)) u_array (
        .clk    (clk),
        .we_i   (byte_we),
        .waddr_i(waddr),
        .wdata_i(wdata),
        .raddr_i(cur_addr),
        .rdata_o(rdata)
    );

    // Drive the bus only for an active read with the output enabled.
    assign bus_drive = active && !out_en_n && !wr_req;

    // R1: reset leaves the bus released.
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !bus_drive);
    // R10: a write request always releases the bus.
    p_wr_tristate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !bus_drive);
    // R3: a primary strobe edge never writes the array.
    p_pri_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_pri_n |-> (byte_we == '0));
    // R2: a strobe seen while deselected ends the access.
    p_desel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        deselect |=> !bus_drive);
endmodule

// File: tb/sram_burst_ctrl_tb.sv
`timescale 1ns/1ps
module sram_burst_ctrl_tb;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] BASE = 6'h14;

    // Vector tables: expected low address bits, indexed by start*4 + beat.
    localparam logic [1:0] LIN_T [16] = '{2'd0, 2'd1, 2'd2, 2'd3,  2'd1, 2'd2, 2'd3, 2'd0,
                                          2'd2, 2'd3, 2'd0, 2'd1,  2'd3, 2'd0, 2'd1, 2'd2};
    localparam logic [1:0] ILV_T [16] = '{2'd0, 2'd1, 2'd2, 2'd3,  2'd1, 2'd0, 2'd3, 2'd2,
                                          2'd2, 2'd3, 2'd0, 2'd1,  2'd3, 2'd2, 2'd1, 2'd0};

    logic clk = 1'b0;
    logic rst_n, sel_a_n, sel_b, sel_c_n, strb_pri_n, strb_sec_n, adv_n;
    logic wr_all_n, wr_en_n, out_en_n, order_sel, bus_drive;
    logic [NB-1:0] byte_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_mem [64];

    always #10 clk = ~clk;

    sram_burst_ctrl #(.AW(AW), .NB(NB), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_pri_n(strb_pri_n), .strb_sec_n(strb_sec_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .byte_wr_n(byte_wr_n),
        .out_en_n(out_en_n), .order_sel(order_sel), .addr(addr), .wdata(wdata),
        .rdata(rdata), .bus_drive(bus_drive)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        return {8'(8'hA5 ^ salt), 8'(a), 8'(~a), 8'(a * 7 + salt)};
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic idle();
        strb_pri_n = 1'b1; strb_sec_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_en_n = 1'b1; byte_wr_n = '1;
    endtask

    // Write through the secondary strobe. R10: the bus must be released at once.
    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d,
                            logic gw, logic bwe, logic [NB-1:0] bw);
        logic [NB-1:0] m;
        m = !gw ? '1 : (!bwe ? ~bw : '0);
        addr = a; wdata = d; strb_sec_n = 1'b0;
        wr_all_n = gw; wr_en_n = bwe; byte_wr_n = bw;
        #1;
        if (m != '0) check("R10 write releases bus", 32'(bus_drive), 32'd0);
        tick();
        for (int i = 0; i < NB; i++)
            if (m[i]) exp_mem[a][8*i +: 8] = d[8*i +: 8];
        idle();
    endtask

    task automatic do_read(logic [AW-1:0] a, bit pri);
        addr = a;
        if (pri) strb_pri_n = 1'b0; else strb_sec_n = 1'b0;
        tick();
        idle();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
        out_en_n = 1'b0; order_sel = 1'b1; addr = '0; wdata = '0;
        idle();
        repeat (3) tick();
        check("R1 bus idle in reset", 32'(bus_drive), 32'd0);
        rst_n = 1'b1; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        tick();
        check("R1 bus idle before access", 32'(bus_drive), 32'd0);

        // Fill every word with write-all (R8).
        for (int a = 0; a < 64; a++) do_write(6'(a), pat(a, 0), 1'b0, 1'b1, '1);
        do_read(6'h05, 1'b0);
        check("R8 write-all stored", rdata, exp_mem[5]);
        check("R10 read drives bus", 32'(bus_drive), 32'd1);

        // Walk the burst tables for both orders.
        for (int m = 0; m < 2; m++) begin
            order_sel = m[0];
            for (int s = 0; s < 4; s++) begin
                do_read(BASE | 6'(s), 1'b0);
                check("R4 start word", rdata, exp_mem[BASE | 6'(s)]);
                adv_n = 1'b0;
                for (int b = 1; b < 4; b++) begin
                    tick();
                    if (m == 0) check("R5 linear beat", rdata, exp_mem[BASE | 6'(LIN_T[s*4+b])]);
                    else        check("R6 interleaved beat", rdata, exp_mem[BASE | 6'(ILV_T[s*4+b])]);
                end
                tick();
                check("R7 wrap to first beat", rdata, exp_mem[BASE | 6'(s)]);
                adv_n = 1'b1;
                tick();
                check("R7 hold without advance", rdata, exp_mem[BASE | 6'(s)]);
            end
        end
        order_sel = 1'b1;

        // Byte writes through the byte gate (R9).
        do_write(6'h21, 32'h11223344, 1'b1, 1'b0, 4'b1010);
        do_read(6'h21, 1'b0);
        check("R9 byte strobes 0 and 2", rdata, (pat(33, 0) & 32'hFF00FF00) | 32'h00220044);
        addr = 6'h21; wdata = 32'hDEADBEEF; strb_sec_n = 1'b0;
        wr_en_n = 1'b1; byte_wr_n = 4'b0000;
        #1;
        check("R10 no request keeps bus driven", 32'(bus_drive), 32'd1);
        tick();
        idle();
        check("R9 gate high writes nothing", rdata, exp_mem[6'h21]);
        out_en_n = 1'b1;
        #1;
        check("R10 output enable off", 32'(bus_drive), 32'd0);
        out_en_n = 1'b0;

        // Continuation write lands at the current burst address (R8).
        do_read(6'h16, 1'b0);
        wdata = 32'hCAFE0123; wr_all_n = 1'b0;
        tick();
        idle();
        exp_mem[6'h16] = 32'hCAFE0123;
        do_read(6'h16, 1'b1);
        check("R8 continuation write", rdata, 32'hCAFE0123);

        // Both strobes low: the primary wins and writes are ignored (R3).
        addr = 6'h30; wdata = 32'h0BADF00D; strb_pri_n = 1'b0; strb_sec_n = 1'b0;
        wr_all_n = 1'b0;
        tick();
        idle();
        check("R3 primary loads address", rdata, exp_mem[6'h30]);
        do_read(6'h30, 1'b1);
        check("R3 primary edge wrote nothing", rdata, exp_mem[6'h30]);

        // Strobe while deselected is ignored (R2).
        do_read(6'h31, 1'b0);
        sel_b = 1'b0; addr = 6'h32; wdata = 32'h55AA55AA;
        strb_sec_n = 1'b0; wr_all_n = 1'b0;
        tick();
        idle();
        sel_b = 1'b1;
        check("R2 deselect releases bus", 32'(bus_drive), 32'd0);
        check("R2 address not loaded", rdata, exp_mem[6'h31]);
        do_read(6'h32, 1'b0);
        check("R2 deselected write ignored", rdata, exp_mem[6'h32]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule